// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds speculative micro-ops between the moment they are allocated in program order and the moment they become architectural. Each cycle it can take up to three new micro-ops, each with a destination register, a write flag, and for branches a predicted direction, a taken target and a fall-through address. It hands back a tag for every accepted micro-op. Execution units report completions against those tags, up to five per cycle and in any order. Each report carries the result, a fault flag and, for branches, the direction the branch actually took.

The oldest entries are inspected every cycle. Up to three completed micro-ops are committed per cycle, oldest first, into a small architectural register file model. A group stops at the first incomplete entry. A faulting entry is never committed; it empties the buffer and requests a restart at its own address. A branch whose direction was mispredicted is committed, every younger entry is discarded, and a restart is requested at the correct path. The buffer therefore always matches a precise instruction boundary.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty, `alloc_ready` is 1, `flush_valid` is 0, `ret_count` is 0, the first offered tag is 0 and every architectural register reads 0.
- R2: Up to three micro-ops are accepted per cycle. Valid slots are taken lowest index first (slot 0 oldest). Accepted micro-ops receive consecutive tags starting at the tail, and a slot whose valid bit is 0 takes no tag.
- R3: `alloc_ready` is 0 while fewer than three entries are free. An allocation offered while it is 0 is ignored: the tail and the offered tags do not move.
- R4: A completion report for a tag marks that entry done and stores its 64-bit result. Up to five reports are taken per cycle, in any tag order.
- R5: Each cycle, up to three done entries are committed from the head in order, stopping at the first entry that is not done. Each committed entry whose write flag is set writes its result to its destination register. When two entries in one group write the same register, the younger value remains. `ret_count` shows, one cycle later, how many entries were committed.
- R6: A committed branch whose reported direction differs from its prediction discards every younger entry. `flush_valid` pulses for one cycle with `flush_addr` equal to the taken target if the branch was taken, or the fall-through address if it was not. The next tag offered follows the branch.
- R7: A done entry reported as faulting is not committed. Older entries in the same group still commit. The buffer is emptied, and `flush_valid` pulses with `flush_addr` equal to the entry's own address. The next tag offered is the faulting entry's tag.
- R8: A branch whose reported direction matches its prediction commits like any other micro-op and raises no flush.
- R9: Tags and pointers wrap from 39 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 3 | Per-slot allocation request |
| alloc_wr | input | 3 | Per-slot: micro-op writes a register |
| alloc_br | input | 3 | Per-slot: micro-op is a branch |
| alloc_pred_tk | input | 3 | Per-slot predicted direction (1 = taken) |
| alloc_dest | input | 9 | Per-slot 3-bit destination register |
| alloc_pc | input | 96 | Per-slot 32-bit micro-op address |
| alloc_target | input | 96 | Per-slot 32-bit taken target |
| alloc_fall | input | 96 | Per-slot 32-bit fall-through address |
| alloc_ready | output | 1 | At least three entries free |
| alloc_tag | output | 18 | Per-slot 6-bit tag offered this cycle |
| cpl_valid | input | 5 | Per-port completion strobe |
| cpl_fault | input | 5 | Per-port fault flag |
| cpl_taken | input | 5 | Per-port actual branch direction |
| cpl_tag | input | 30 | Per-port 6-bit tag |
| cpl_data | input | 320 | Per-port 64-bit result |
| ret_count | output | 2 | Entries committed in the previous cycle |
| flush_valid | output | 1 | Restart request pulse |
| flush_addr | output | 32 | Restart address |
| arf_raddr | input | 3 | Architectural register read address |
| arf_rdata | output | 64 | Architectural register read data |

## Verification
The hardest state to reach is a full buffer whose head has already moved off zero. The tag sequence must cross the 39-to-0 boundary, and an ignored allocation must be shown to leave the tail alone. The bench first flushes the buffer from a non-zero head by means of mispredicts and faults. It then allocates three micro-ops a cycle without completing any until `alloc_ready` falls. Finally it drains the whole buffer in one step by reporting a fault on the oldest entry. Gaps in a retire group, same-register writes inside a group, and both mispredict directions each get their own short sequence.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int DATA_W  = 64;
    localparam int ADDR_W  = 32;
    localparam int NREG    = 8;
    localparam int REG_W   = $clog2(NREG);
    localparam int ALLOC_W = 3;
    localparam int RET_W   = 3;
    localparam int CPL_W   = 5;

    typedef struct packed {
        logic              done;
        logic              fault;
        logic              wr;
        logic              br;
        logic              pred_tk;
        logic              act_tk;
        logic [REG_W-1:0]  dest;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] fall;
        logic [DATA_W-1:0] data;
    } rob_entry_t;

    // Circular pointer advance; k never exceeds depth.
    function automatic int unsigned wrap_add(int unsigned p, int unsigned k, int unsigned depth);
        int unsigned s;
        s = p + k;
        return (s >= depth) ? s - depth : s;
    endfunction
endpackage

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0]  count,
    input  rob_entry_t        win [RET_W],
    output logic [RET_W-1:0]  commit,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_addr,
    output logic [1:0]        n_ret
);
    always_comb begin
        logic go;
        go         = 1'b1;
        commit     = '0;
        flush      = 1'b0;
        flush_addr = '0;
        n_ret      = '0;
        for (int k = 0; k < RET_W; k++) begin
            if (go && (32'(count) > k) && win[k].done) begin
                if (win[k].fault) begin
                    flush      = 1'b1;
                    flush_addr = win[k].pc;
                    go         = 1'b0;
                end else begin
                    commit[k] = 1'b1;
                    n_ret     = n_ret + 2'd1;
                    if (win[k].br && (win[k].act_tk != win[k].pred_tk)) begin
                        flush      = 1'b1;
                        flush_addr = win[k].act_tk ? win[k].target : win[k].fall;
                        go         = 1'b0;
                    end
                end
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_arf.sv
module rob_arf
    import rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RET_W-1:0]  we,
    input  logic [REG_W-1:0]  waddr [RET_W],
    input  logic [DATA_W-1:0] wdata [RET_W],
    input  logic [REG_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [NREG];

    // Higher port index is younger and is applied last.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int k = 0; k < RET_W; k++)
                if (we[k]) regs[waddr[k]] <= wdata[k];
        end
    end

    assign rdata = regs[raddr];

    for (genvar g = 0; g < NREG; g++) begin : g_hold
        a_r5_arf_hold: assert property (@(posedge clk) disable iff (rst)
            !(|we) |=> $stable(regs[g]));
    end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH = 40,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ALLOC_W-1:0]         alloc_valid,
    input  logic [ALLOC_W-1:0]         alloc_wr,
    input  logic [ALLOC_W-1:0]         alloc_br,
    input  logic [ALLOC_W-1:0]         alloc_pred_tk,
    input  logic [ALLOC_W*REG_W-1:0]   alloc_dest,
    input  logic [ALLOC_W*ADDR_W-1:0]  alloc_pc,
    input  logic [ALLOC_W*ADDR_W-1:0]  alloc_target,
    input  logic [ALLOC_W*ADDR_W-1:0]  alloc_fall,
    output logic                       alloc_ready,
    output logic [ALLOC_W*TAG_W-1:0]   alloc_tag,
    input  logic [CPL_W-1:0]           cpl_valid,
    input  logic [CPL_W-1:0]           cpl_fault,
    input  logic [CPL_W-1:0]           cpl_taken,
    input  logic [CPL_W*TAG_W-1:0]     cpl_tag,
    input  logic [CPL_W*DATA_W-1:0]    cpl_data,
    output logic [1:0]                 ret_count,
    output logic                       flush_valid,
    output logic [ADDR_W-1:0]          flush_addr,
    input  logic [REG_W-1:0]           arf_raddr,
    output logic [DATA_W-1:0]          arf_rdata
);
    rob_entry_t        ent [DEPTH];
    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;

    logic [TAG_W-1:0]  slot_tag [ALLOC_W];
    logic [ALLOC_W-1:0] acc;
    logic [1:0]        n_alloc;

    rob_entry_t        win [RET_W];
    logic [RET_W-1:0]  commit;
    logic              flush;
    logic [ADDR_W-1:0] f_addr;
    logic [1:0]        n_ret;
    logic [TAG_W-1:0]  head_nx;

    logic [RET_W-1:0]  arf_we;
    logic [REG_W-1:0]  arf_wa [RET_W];
    logic [DATA_W-1:0] arf_wd [RET_W];

    // ---------------- allocation ----------------
    assign alloc_ready = (32'(count) + ALLOC_W) <= DEPTH;
    assign acc         = alloc_valid & {ALLOC_W{alloc_ready && !flush}};
    assign n_alloc     = 2'($countones(acc));

    always_comb begin
        int unsigned off;
        off = 0;
        for (int k = 0; k < ALLOC_W; k++) begin
            slot_tag[k] = TAG_W'(wrap_add(32'(tail), off, DEPTH));
            if (alloc_valid[k]) off = off + 1;
        end
    end

    for (genvar g = 0; g < ALLOC_W; g++) begin : g_tag
        assign alloc_tag[g*TAG_W +: TAG_W] = slot_tag[g];
    end

    // ---------------- retire window ----------------
    for (genvar g = 0; g < RET_W; g++) begin : g_win
        assign win[g]    = ent[TAG_W'(wrap_add(32'(head), g, DEPTH))];
        assign arf_we[g] = commit[g] && win[g].wr;
        assign arf_wa[g] = win[g].dest;
        assign arf_wd[g] = win[g].data;
    end

    rob_retire_sel #(.CNT_W(CNT_W)) u_sel (
        .count      (count),
        .win        (win),
        .commit     (commit),
        .flush      (flush),
        .flush_addr (f_addr),
        .n_ret      (n_ret)
    );

    assign head_nx = TAG_W'(wrap_add(32'(head), 32'(n_ret), DEPTH));

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            head        <= '0;
            tail        <= '0;
            count       <= '0;
            ret_count   <= '0;
            flush_valid <= 1'b0;
            flush_addr  <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            ret_count   <= n_ret;
            flush_valid <= flush;
            flush_addr  <= f_addr;
            for (int j = 0; j < CPL_W; j++) begin
                if (cpl_valid[j]) begin
                    ent[cpl_tag[j*TAG_W +: TAG_W]].done   <= 1'b1;
                    ent[cpl_tag[j*TAG_W +: TAG_W]].fault  <= cpl_fault[j];
                    ent[cpl_tag[j*TAG_W +: TAG_W]].act_tk <= cpl_taken[j];
                    ent[cpl_tag[j*TAG_W +: TAG_W]].data   <= cpl_data[j*DATA_W +: DATA_W];
                end
            end
            for (int k = 0; k < ALLOC_W; k++) begin
                if (acc[k]) begin
                    ent[slot_tag[k]].done    <= 1'b0;
                    ent[slot_tag[k]].fault   <= 1'b0;
                    ent[slot_tag[k]].act_tk  <= 1'b0;
                    ent[slot_tag[k]].wr      <= alloc_wr[k];
                    ent[slot_tag[k]].br      <= alloc_br[k];
                    ent[slot_tag[k]].pred_tk <= alloc_pred_tk[k];
                    ent[slot_tag[k]].dest    <= alloc_dest[k*REG_W +: REG_W];
                    ent[slot_tag[k]].pc      <= alloc_pc[k*ADDR_W +: ADDR_W];
                    ent[slot_tag[k]].target  <= alloc_target[k*ADDR_W +: ADDR_W];
                    ent[slot_tag[k]].fall    <= alloc_fall[k*ADDR_W +: ADDR_W];
                end
            end
            head <= head_nx;
            if (flush) begin
                tail  <= head_nx;
                count <= '0;
            end else begin
                tail  <= TAG_W'(wrap_add(32'(tail), 32'(n_alloc), DEPTH));
                count <= count - CNT_W'(n_ret) + CNT_W'(n_alloc);
            end
        end
    end

    rob_arf u_arf (
        .clk   (clk),
        .rst   (rst),
        .we    (arf_we),
        .waddr (arf_wa),
        .wdata (arf_wd),
        .raddr (arf_raddr),
        .rdata (arf_rdata)
    );

    // ---------------- assertions ----------------
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        32'(count) <= DEPTH);

    a_r3_full_holds_tail: assert property (@(posedge clk) disable iff (rst)
        (!alloc_ready && !flush) |=> (tail == $past(tail)));

    a_r9_ptr_consistent: assert property (@(posedge clk) disable iff (rst)
        tail == TAG_W'(wrap_add(32'(head), 32'(count), DEPTH)));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> (count == '0));

    for (genvar g = 0; g < RET_W; g++) begin : g_chk
        a_r7_commit_clean: assert property (@(posedge clk) disable iff (rst)
            commit[g] |-> (win[g].done && !win[g].fault));
    end
endmodule

// File: tb/tb_reorder_buffer.sv
module tb_reorder_buffer;
    import rob_pkg::*;
    localparam int DEPTH = 40;
    localparam int TAG_W = 6;

    logic                      clk = 1'b0;
    logic                      rst;
    logic [ALLOC_W-1:0]        alloc_valid, alloc_wr, alloc_br, alloc_pred_tk;
    logic [ALLOC_W*REG_W-1:0]  alloc_dest;
    logic [ALLOC_W*ADDR_W-1:0] alloc_pc, alloc_target, alloc_fall;
    logic                      alloc_ready;
    logic [ALLOC_W*TAG_W-1:0]  alloc_tag;
    logic [CPL_W-1:0]          cpl_valid, cpl_fault, cpl_taken;
    logic [CPL_W*TAG_W-1:0]    cpl_tag;
    logic [CPL_W*DATA_W-1:0]   cpl_data;
    logic [1:0]                ret_count;
    logic                      flush_valid;
    logic [ADDR_W-1:0]         flush_addr;
    logic [REG_W-1:0]          arf_raddr;
    logic [DATA_W-1:0]         arf_rdata;

    always #5 clk = ~clk;

    reorder_buffer dut (.*);

    int checks = 0;
    int errors = 0;
    int exp_tail = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_slot(int k, int dest, bit wr, bit br, bit pt,
                            logic [31:0] tgt, logic [31:0] fall, logic [31:0] pc);
        alloc_dest[k*REG_W +: REG_W]     = REG_W'(dest);
        alloc_wr[k]                      = wr;
        alloc_br[k]                      = br;
        alloc_pred_tk[k]                 = pt;
        alloc_target[k*ADDR_W +: ADDR_W] = tgt;
        alloc_fall[k*ADDR_W +: ADDR_W]   = fall;
        alloc_pc[k*ADDR_W +: ADDR_W]     = pc;
    endtask

    // Offers an allocation, checks the compacted tags, then clocks it in.
    task automatic do_alloc(logic [2:0] mask, string req);
        int off = 0;
        alloc_valid = mask;
        #1;
        for (int k = 0; k < ALLOC_W; k++) begin
            if (mask[k]) begin
                chk(req, 64'(alloc_tag[k*TAG_W +: TAG_W]), 64'((exp_tail + off) % DEPTH));
                off++;
            end
        end
        step();
        alloc_valid = '0;
        exp_tail = (exp_tail + off) % DEPTH;
    endtask

    task automatic cpl(int p, int tag, bit fault, bit taken);
        cpl_valid[p]                   = 1'b1;
        cpl_tag[p*TAG_W +: TAG_W]      = TAG_W'(tag);
        cpl_data[p*DATA_W +: DATA_W]   = 64'hD000 + 64'(tag);
        cpl_fault[p]                   = fault;
        cpl_taken[p]                   = taken;
    endtask

    task automatic cpl_go();
        step();
        cpl_valid = '0;
        cpl_fault = '0;
        cpl_taken = '0;
    endtask

    task automatic chk_reg(string req, int r, logic [63:0] exp);
        arf_raddr = REG_W'(r);
        #1;
        chk(req, arf_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1 ready", 64'(alloc_ready), 1);
        chk("R1 flush", 64'(flush_valid), 0);
        chk("R1 ret_count", 64'(ret_count), 0);
        chk("R1 first tag", 64'(alloc_tag[TAG_W-1:0]), 0);
        chk_reg("R1 arf r1", 1, 0);
        chk_reg("R1 arf r7", 7, 0);
    endtask

    task automatic t_basic();
        set_slot(0, 1, 1, 0, 0, 0, 0, 32'h10);
        set_slot(1, 2, 1, 0, 0, 0, 0, 32'h14);
        set_slot(2, 3, 1, 0, 0, 0, 0, 32'h18);
        do_alloc(3'b111, "R2");
        cpl(4, 2, 0, 0); cpl(2, 0, 0, 0); cpl(0, 1, 0, 0);
        cpl_go();
        chk("R5 none before done", 64'(ret_count), 0);
        step();
        chk("R5 three retire", 64'(ret_count), 3);
        chk_reg("R4 r1", 1, 64'hD000);
        chk_reg("R4 r2", 2, 64'hD001);
        chk_reg("R4 r3", 3, 64'hD002);
    endtask

    task automatic t_gap();
        set_slot(0, 4, 1, 0, 0, 0, 0, 32'h20);
        set_slot(1, 5, 1, 0, 0, 0, 0, 32'h24);
        set_slot(2, 6, 1, 0, 0, 0, 0, 32'h28);
        do_alloc(3'b111, "R2");
        cpl(1, 3, 0, 0); cpl(3, 5, 0, 0);
        cpl_go();
        step();
        chk("R5 stop at gap", 64'(ret_count), 1);
        chk_reg("R5 r4", 4, 64'hD003);
        chk_reg("R5 r6 held", 6, 0);
        cpl(0, 4, 0, 0);
        cpl_go();
        step();
        chk("R5 rest retire", 64'(ret_count), 2);
        chk_reg("R5 r5", 5, 64'hD004);
        chk_reg("R5 r6", 6, 64'hD005);
    endtask

    task automatic t_compact();
        set_slot(0, 7, 1, 0, 0, 0, 0, 32'h30);
        set_slot(2, 1, 1, 0, 0, 0, 0, 32'h34);
        do_alloc(3'b101, "R2 compacted");
        cpl(0, 6, 0, 0); cpl(1, 7, 0, 0);
        cpl_go();
        step();
        chk("R2 two retire", 64'(ret_count), 2);
        chk_reg("R2 r1", 1, 64'hD007);
        // same destination in one group
        set_slot(0, 2, 1, 0, 0, 0, 0, 0);
        set_slot(1, 2, 1, 0, 0, 0, 0, 0);
        set_slot(2, 2, 1, 0, 0, 0, 0, 0);
        do_alloc(3'b111, "R2");
        cpl(0, 10, 0, 0); cpl(1, 8, 0, 0); cpl(2, 9, 0, 0);
        cpl_go();
        step();
        chk("R5 group", 64'(ret_count), 3);
        chk_reg("R5 youngest wins", 2, 64'hD00A);
    endtask

    task automatic t_branch_ok();
        set_slot(0, 3, 1, 0, 0, 0, 0, 32'h40);
        set_slot(1, 0, 0, 1, 1, 32'h100, 32'h44, 32'h40);
        set_slot(2, 3, 1, 0, 0, 0, 0, 32'h100);
        do_alloc(3'b111, "R2");
        cpl(0, 11, 0, 0); cpl(1, 12, 0, 1); cpl(2, 13, 0, 0);
        cpl_go();
        step();
        chk("R8 retire", 64'(ret_count), 3);
        chk("R8 no flush", 64'(flush_valid), 0);
        chk_reg("R8 r3", 3, 64'hD00D);
    endtask

    task automatic t_mispredict();
        set_slot(0, 4, 1, 0, 0, 0, 0, 32'h80);
        set_slot(1, 0, 0, 1, 0, 32'h200, 32'h84, 32'h80);
        set_slot(2, 5, 1, 0, 0, 0, 0, 32'h84);
        do_alloc(3'b111, "R2");
        cpl(3, 14, 0, 0); cpl(4, 15, 0, 1); cpl(0, 16, 0, 0);
        cpl_go();
        step();
        chk("R6 retire to branch", 64'(ret_count), 2);
        chk("R6 flush", 64'(flush_valid), 1);
        chk("R6 taken target", 64'(flush_addr), 64'h200);
        chk_reg("R6 r4", 4, 64'hD00E);
        chk_reg("R6 r5 held", 5, 64'hD004);
        exp_tail = 16;
        step();
        chk("R6 pulse", 64'(flush_valid), 0);
        set_slot(0, 0, 0, 1, 1, 32'h300, 32'h88, 32'h84);
        set_slot(1, 6, 1, 0, 0, 0, 0, 32'h300);
        do_alloc(3'b011, "R6 tag after branch");
        cpl(0, 16, 0, 0); cpl(1, 17, 0, 0);
        cpl_go();
        step();
        chk("R6 nt retire", 64'(ret_count), 1);
        chk("R6 fall-through", 64'(flush_addr), 64'h88);
        chk_reg("R6 r6 held", 6, 64'hD005);
        exp_tail = 17;
    endtask

    task automatic t_fault();
        set_slot(0, 7, 1, 0, 0, 0, 0, 32'hBAC0);
        set_slot(1, 1, 1, 0, 0, 0, 0, 32'hBAD0);
        set_slot(2, 2, 1, 0, 0, 0, 0, 32'hBAE0);
        do_alloc(3'b111, "R2");
        cpl(0, 17, 0, 0); cpl(1, 18, 1, 0); cpl(2, 19, 0, 0);
        cpl_go();
        step();
        chk("R7 older commits", 64'(ret_count), 1);
        chk("R7 flush", 64'(flush_valid), 1);
        chk("R7 addr", 64'(flush_addr), 64'hBAD0);
        chk_reg("R7 r7", 7, 64'hD011);
        chk_reg("R7 r1 held", 1, 64'hD007);
        chk_reg("R7 r2 held", 2, 64'hD00A);
        exp_tail = 18;
    endtask

    task automatic t_full();
        set_slot(0, 0, 0, 0, 0, 0, 0, 32'h1000);
        set_slot(1, 0, 0, 0, 0, 0, 0, 32'h1004);
        set_slot(2, 0, 0, 0, 0, 0, 0, 32'h1008);
        for (int i = 0; i < 13; i++) begin
            chk("R3 ready while room", 64'(alloc_ready), 1);
            do_alloc(3'b111, "R9");
        end
        chk("R3 full", 64'(alloc_ready), 0);
        chk("R9 wrapped tail", 64'(alloc_tag[TAG_W-1:0]), 17);
        alloc_valid = 3'b111;
        step();
        alloc_valid = '0;
        #1;
        chk("R3 ignored tail", 64'(alloc_tag[TAG_W-1:0]), 17);
        chk("R3 still full", 64'(alloc_ready), 0);
        cpl(2, 18, 1, 0);
        cpl_go();
        step();
        chk("R7 drain flush", 64'(flush_addr), 64'h1000);
        chk("R3 ready again", 64'(alloc_ready), 1);
        chk("R7 tag restart", 64'(alloc_tag[TAG_W-1:0]), 18);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        alloc_valid = '0; alloc_wr = '0; alloc_br = '0; alloc_pred_tk = '0;
        alloc_dest = '0; alloc_pc = '0; alloc_target = '0; alloc_fall = '0;
        cpl_valid = '0; cpl_fault = '0; cpl_taken = '0; cpl_tag = '0; cpl_data = '0;
        arf_raddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_gap();
        t_compact();
        t_branch_ok();
        t_mispredict();
        t_fault();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule